// File: doc/BRIEF.md
# Write-Leveling Delay Calibrator

This block calibrates the strobe delay of a single byte lane of a DDR3-style memory interface. The strobe output delay is moved in taps, each tap a fraction of the clock period. At every tap the block lets the delay line settle and then fires a short run of strobe pulses. The memory samples its clock on the rising edge of each strobe and returns that level on the lowest data bit of the lane. The block takes a majority vote over the returned levels for that tap. It stops at the first tap whose vote is 1 when the previous tap's vote was 0. That tap is the lane's deskew value.

Each byte lane gets its own instance, so every lane has its own delay value. A one-cycle start pulse starts a run. While the run is active, `tap_o` drives the external delay line. When the run ends, `tap_o` holds the result, `done_o` is high, and `err_o` is high if no 0-to-1 change was seen by the last tap. These outputs stay as they are until the next start. The parameters `SETTLE_CYC`, `RESP_LAT` and `N_SMP` must be at least 1, and `N_SMP` should be odd.

Top module: `wl_calib`

## Requirements
- R1: While reset is held and after it is released, `tap_o` is 0 and `done_o`, `err_o`, `busy_o` and `dqs_pulse_o` are all 0.
- R2: A `start_i` high for one cycle while idle starts a run. From the next cycle `busy_o` is 1, `tap_o` is 0, and `done_o` and `err_o` are 0. A `start_i` that arrives while busy has no effect on the run, its result or its duration.
- R3: At every tap the block waits `SETTLE_CYC` cycles. It then emits `N_SMP` strobe pulses, each exactly one cycle long, with the rising edges `RESP_LAT`+2 cycles apart. `dqs_pulse_o` is never high outside a run.
- R4: `lvl_i` is sampled only in the cycle that lies `RESP_LAT`+1 cycles after the cycle in which the pulse was high. Its value in any other cycle has no effect on the result.
- R5: The level for a tap is 1 when more than half of its `N_SMP` samples are 1. A minority of samples that disagree does not change the level.
- R6: The run ends at the first tap t greater than 0 whose level is 1 while the level of tap t-1 was 0. At that point `tap_o` equals t, `done_o` is 1 and `err_o` is 0.
- R7: If the last tap (2^`TAP_W`-1) is reached without such a change, the run ends with `tap_o` at the last tap and both `done_o` and `err_o` at 1. A lane that returns 1 at tap 0 and at every later tap takes this path.
- R8: A 0-to-1 change found at the last tap ends the run as a success: `done_o` is 1 and `err_o` is 0.
- R9: After a run ends, `busy_o` is 0, and `tap_o`, `done_o` and `err_o` stay unchanged until the next accepted start.
- R10: `done_o` rises exactly (`SETTLE_CYC` + `N_SMP`*(`RESP_LAT`+2) + 1)*(t+1) clock cycles after the edge that accepted the start, where t is the final tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin calibration |
| lvl_i | input | 1 | Clock level sampled by the memory, returned on the lane's lowest data bit |
| tap_o | output | TAP_W | Current strobe delay tap; holds the result after the run |
| dqs_pulse_o | output | 1 | One-cycle request for a leveling strobe pulse |
| busy_o | output | 1 | A calibration run is in progress |
| done_o | output | 1 | The run has ended; the result is valid |
| err_o | output | 1 | The run ended without finding a 0-to-1 change |

## Verification
Two functions can fall into the same decision cycle: detecting the 0-to-1 change and reaching the end of the tap range. The bench provokes this with a modelled lane whose clock edge sits exactly at the last tap. A success there with `err_o` low is the correct result. The bench runs the opposite cases as well: a lane that never returns 1, and a lane that returns 1 from tap 0. Both must raise the error. Jittery samples next to the edge test the majority vote. Levels that are inverted everywhere except in the capture cycle show that only that cycle is used.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PULSE,
    ST_WAIT,
    ST_CAPTURE,
    ST_DECIDE
  } wl_state_e;

  // Majority over a fixed number of samples: strictly more than half.
  function automatic logic maj_vote(input int unsigned ones, input int unsigned total);
    return (2 * ones) > total;
  endfunction

  // Cycles spent on one tap, from entering settle to leaving decide.
  function automatic int unsigned step_cycles(input int unsigned settle,
                                              input int unsigned lat,
                                              input int unsigned n_smp);
    return settle + n_smp * (lat + 2) + 1;
  endfunction

endpackage

// File: rtl/wl_interval_timer.sv
module wl_interval_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last_o = (cnt_q == CNT_W'(1));

  // The counter walks down one per cycle once loaded (R3 timing base).
  p_timer_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // A count that has reached zero stays there until it is loaded again.
  p_timer_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/wl_vote_acc.sv
module wl_vote_acc
  import wl_pkg::*;
#(
  parameter int N_SMP = 3,
  localparam int CNT_W = $clog2(N_SMP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic smp_en_i,
  input  logic bit_i,
  output logic last_smp_o,
  output logic vote_o
);

  logic [CNT_W-1:0] ones_q;
  logic [CNT_W-1:0] taken_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q  <= '0;
      taken_q <= '0;
    end else if (clr_i) begin
      ones_q  <= '0;
      taken_q <= '0;
    end else if (smp_en_i) begin
      taken_q <= taken_q + CNT_W'(1);
      if (bit_i) ones_q <= ones_q + CNT_W'(1);
    end
  end

  assign last_smp_o = (taken_q == CNT_W'(N_SMP - 1));
  assign vote_o     = maj_vote(int'(ones_q), N_SMP);

  // The sample count never passes the number of samples per tap (R5).
  p_taken_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q <= CNT_W'(N_SMP));

  // The ones count never passes the number of samples taken (R5).
  p_ones_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= taken_q);

endmodule

// File: rtl/wl_tap_track.sv
module wl_tap_track #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             decide_i,
  input  logic             vote_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             found_o,
  output logic             at_max_o
);

  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  logic [TAP_W-1:0] tap_q;
  logic             prev_vote_q;
  logic             prev_valid_q;
  logic             advance;

  assign found_o  = decide_i && prev_valid_q && !prev_vote_q && vote_i;
  assign at_max_o = (tap_q == TAP_MAX);
  assign advance  = decide_i && !found_o && !at_max_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_q        <= '0;
      prev_vote_q  <= 1'b0;
      prev_valid_q <= 1'b0;
    end else if (clr_i) begin
      tap_q        <= '0;
      prev_vote_q  <= 1'b0;
      prev_valid_q <= 1'b0;
    end else if (advance) begin
      tap_q        <= tap_q + TAP_W'(1);
      prev_vote_q  <= vote_i;
      prev_valid_q <= 1'b1;
    end
  end

  assign tap_o = tap_q;

  // The tap moves only on a clear or a decision (R6, R9).
  p_tap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !decide_i) |=> $stable(tap_q));

  // A found change freezes the tap at the step where it was seen (R6).
  p_found_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (found_o && !clr_i) |=> $stable(tap_q));

  // A change can only be reported after at least one earlier step (R6).
  p_found_needs_prev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (tap_q != '0));

endmodule

// File: rtl/wl_calib.sv
module wl_calib
  import wl_pkg::*;
#(
  parameter int TAP_W      = 5,
  parameter int SETTLE_CYC = 4,
  parameter int RESP_LAT   = 3,
  parameter int N_SMP      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             lvl_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             dqs_pulse_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  localparam int TMR_MAX = (SETTLE_CYC > RESP_LAT) ? SETTLE_CYC : RESP_LAT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  wl_state_e state_q, state_d;
  logic done_q, err_q;

  // Named internal events.
  logic start_acc;
  logic tmr_last;
  logic tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic smp_en;
  logic smp_last;
  logic vote;
  logic decide;
  logic found;
  logic at_max;
  logic next_step;
  logic end_ok;
  logic end_err;

  assign start_acc = start_i && (state_q == ST_IDLE);
  assign smp_en    = (state_q == ST_CAPTURE);
  assign decide    = (state_q == ST_DECIDE);
  assign end_ok    = decide && found;
  assign end_err   = decide && !found && at_max;
  assign next_step = decide && !found && !at_max;

  assign tmr_load = start_acc || next_step || (state_q == ST_PULSE);
  assign tmr_val  = (state_q == ST_PULSE) ? TMR_W'(RESP_LAT) : TMR_W'(SETTLE_CYC);

  wl_interval_timer #(.CNT_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .last_o     (tmr_last)
  );

  wl_vote_acc #(.N_SMP(N_SMP)) u_vote (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start_acc || decide),
    .smp_en_i   (smp_en),
    .bit_i      (lvl_i),
    .last_smp_o (smp_last),
    .vote_o     (vote)
  );

  wl_tap_track #(.TAP_W(TAP_W)) u_tap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (start_acc),
    .decide_i (decide),
    .vote_i   (vote),
    .tap_o    (tap_o),
    .found_o  (found),
    .at_max_o (at_max)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_SETTLE;
      ST_SETTLE:  if (tmr_last) state_d = ST_PULSE;
      ST_PULSE:   state_d = ST_WAIT;
      ST_WAIT:    if (tmr_last) state_d = ST_CAPTURE;
      ST_CAPTURE: state_d = smp_last ? ST_DECIDE : ST_PULSE;
      ST_DECIDE:  state_d = next_step ? ST_SETTLE : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_acc) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (end_ok) begin
        done_q <= 1'b1;
      end else if (end_err) begin
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end
    end
  end

  assign dqs_pulse_o = (state_q == ST_PULSE);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;

  // Strobe pulses only during a run and never two cycles in a row (R3).
  p_pulse_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pulse_o |-> busy_o);
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pulse_o |=> !dqs_pulse_o);

  // Error is only ever shown together with done (R7).
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // Done and busy exclude each other (R9).
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // The result holds while idle and no start arrives (R9).
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(tap_o) && $stable(done_o) && $stable(err_o)));

  // An accepted start begins a clean run at tap 0 (R2).
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !done_o && !err_o && tap_o == '0));

  // A success at the last tap never raises the error (R8).
  p_max_success_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && found && at_max) |=> (done_o && !err_o));

endmodule

// File: tb/tb_wl_calib.sv
module tb_wl_calib;

  localparam int TAP_W      = 5;
  localparam int SETTLE_CYC = 4;
  localparam int RESP_LAT   = 3;
  localparam int N_SMP      = 3;
  localparam int TAP_LAST   = (1 << TAP_W) - 1;
  localparam int STEP       = SETTLE_CYC + N_SMP * (RESP_LAT + 2) + 1;
  localparam int N_VEC      = 8;

  // Vector: {clock edge tap, jitter near edge, noise outside capture}
  localparam int VEC_EDGE [N_VEC] = '{5, 12, 1, 31, 0, 99, 20, 9};
  localparam int VEC_JIT  [N_VEC] = '{0, 1,  0, 0,  0, 0,  1,  1};
  localparam int VEC_NOIS [N_VEC] = '{0, 0,  0, 0,  0, 0,  1,  1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic lvl_i = 1'b0;
  logic [TAP_W-1:0] tap_o;
  logic dqs_pulse_o, busy_o, done_o, err_o;

  int errors = 0;
  int checks = 0;
  int edge_tap = 99;
  int jit = 0;
  int noisy = 0;
  int pulse_total = 0;
  int pulse_base = 0;
  int since = 100;
  logic resp = 1'b0;
  int gcyc = 0;

  always #2.5 clk = ~clk;

  wl_calib #(.TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC), .RESP_LAT(RESP_LAT), .N_SMP(N_SMP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lvl_i(lvl_i),
    .tap_o(tap_o), .dqs_pulse_o(dqs_pulse_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  // Memory model: level seen for a given tap and pulse index within the tap.
  function automatic logic mem_level(int tap, int edg, int jt, int idx);
    if (tap > edg) return 1'b1;
    if (tap == edg) return (jt != 0 && idx == 0) ? 1'b0 : 1'b1;
    if (jt != 0 && tap == edg - 1 && idx == 1) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int exp_tap(int edg);
    return (edg == 0 || edg > TAP_LAST) ? TAP_LAST : edg;
  endfunction

  always @(posedge clk) begin
    gcyc <= gcyc + 1;
    if (dqs_pulse_o) begin
      resp <= mem_level(int'(tap_o), edge_tap, jit, (pulse_total - pulse_base) % N_SMP);
      pulse_total <= pulse_total + 1;
      since <= 0;
    end else if (since < 100) begin
      since <= since + 1;
    end
  end

  always @(negedge clk) begin
    lvl_i <= (noisy == 0 || since == RESP_LAT) ? resp : ~resp;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Runs one calibration; an extra start is pulsed at cycle extra_at (if >0).
  task automatic run_cal(int edg, int jt, int ns, int extra_at);
    int cyc;
    int exp_t;
    exp_t = exp_tap(edg);
    edge_tap = edg; jit = jt; noisy = ns;
    @(negedge clk);
    pulse_base = pulse_total;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", int'(busy_o), 1);
    chk("R2 tap cleared", int'(tap_o), 0);
    chk("R2 done cleared", int'(done_o), 0);
    cyc = 0;
    while (!done_o && cyc < 3000) begin
      start_i = (extra_at > 0 && cyc == extra_at);
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R6 R7 R8 final tap", int'(tap_o), exp_t);
    chk("R7 R8 error flag", int'(err_o), (exp_t == TAP_LAST && edg != TAP_LAST) ? 1 : 0);
    chk("R9 not busy at done", int'(busy_o), 0);
    chk("R10 done latency", cyc, STEP * (exp_t + 1));
    chk("R3 R5 pulse count", pulse_total - pulse_base, N_SMP * (exp_t + 1));
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 tap in reset", int'(tap_o), 0);
    chk("R1 flags in reset", int'({done_o, err_o, busy_o, dqs_pulse_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 tap after reset", int'(tap_o), 0);
    chk("R1 flags after reset", int'({done_o, err_o, busy_o, dqs_pulse_o}), 0);

    // Table walk: R4 noise, R5 jitter, R6 edges, R7 never/always, R8 last tap
    for (int i = 0; i < N_VEC; i++) begin
      run_cal(VEC_EDGE[i], VEC_JIT[i], VEC_NOIS[i], 0);
    end

    // R9: result holds while idle; stray inputs do not disturb it
    begin
      int held_tap;
      held_tap = int'(tap_o);
      noisy = 1;
      repeat (40) @(negedge clk);
      chk("R9 tap held", int'(tap_o), held_tap);
      chk("R9 done held", int'(done_o), 1);
      chk("R9 no pulses when idle", int'(dqs_pulse_o), 0);
    end

    // R2: start while busy is ignored
    run_cal(6, 0, 0, 50);
    run_cal(6, 1, 1, 7);

    // R4: all-noise lane with edge inside range still found exactly
    run_cal(2, 0, 1, 0);

    finish_run();
  end

  initial begin
    wait (gcyc >= 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", gcyc, 0);
    finish_run();
  end

endmodule